// File: doc/BRIEF.md
# DDR2 Bus Command Decoder with Clock-Enable Tracking

This block watches the command strobes of a DDR2 memory bus and names the command present at each rising clock edge. It samples chip select, the row and column strobes, write enable, clock enable, the bank bits and address bit 10. It also keeps the clock enable seen at the previous edge. Clock enable is used from both the previous and the current edge, so refresh versus self-refresh, and power-down entry and exit, are told apart. Address bit 10 and the bank bits split precharge, the column commands and the mode-register writes into separate command variants. The block is meant for a bus monitor, a protocol checker or a memory model front end. It does not check timing, schedule refresh or touch data.

The result is one registered one-hot command vector, a bank field and a one-cycle illegal-command pulse, all valid the cycle after the sampling edge. Two status flags follow the power mode and change one cycle after the command that moves it. All pins are plain control and status signals. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ddr2_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, before any edge samples the bus, `cmd_oh`, `bank_o`, `illegal_o`, `pd_o` and `sr_o` are all zero. The stored previous clock enable resets to high.
- R2: The `cmd_oh` bit positions are: 0 MRS, 1 EMRS1, 2 EMRS2, 3 auto-refresh, 4 self-refresh entry, 5 self-refresh exit, 6 precharge one bank, 7 precharge all, 8 activate, 9 write, 10 write+AP, 11 read, 12 read+AP, 13 NOP, 14 deselect, 15 power-down entry, 16 power-down exit. With clock enable high at both edges, chip select high gives deselect. Chip select low with the RAS, CAS and WE strobes all high gives NOP.
- R3: With clock enable high at both edges and chip select, RAS, CAS and WE all low, the command is a mode-register write. Bank bits {ba[1],ba[0]} = 00 give MRS, 01 give EMRS1 and 10 give EMRS2. The value 11, or any higher bank bit set, is illegal.
- R4: Chip select, RAS and CAS low with WE high is auto-refresh when clock enable is high at both edges. It is self-refresh entry when clock enable goes from high to low.
- R5: RAS low, CAS high and WE low is precharge. With a10 low it is one-bank precharge, and `bank_o` carries the bank bits. With a10 high it is precharge-all, and `bank_o` is zero.
- R6: RAS low with CAS and WE high is activate, and `bank_o` carries the bank bits.
- R7: RAS high with CAS low is a column command. WE low gives write and WE high gives read. a10 high selects the auto-precharge variant of either. `bank_o` carries the bank bits. For every command that names no bank, `bank_o` is zero.
- R8: Clock enable going from high to low with deselect or NOP on the bus is power-down entry. `pd_o` rises one cycle after `cmd_oh` shows the entry.
- R9: Clock enable going from low to high with deselect or NOP on the bus is an exit. It is reported as self-refresh exit when the block is in self-refresh, and as power-down exit otherwise. The matching flag (`sr_o` or `pd_o`) falls one cycle after the exit is shown. `sr_o` rises one cycle after a self-refresh entry is shown.
- R10: With clock enable low at both edges, `cmd_oh` is zero, `illegal_o` is low and the power flags hold.
- R11: `illegal_o` pulses for one cycle, with `cmd_oh` zero and the power mode unchanged, in three cases. The first is strobes RAS/CAS high and WE low with chip select low under clock enable high at both edges. The second is a high-to-low clock enable with a bus that is neither idle nor refresh. The third is a low-to-high clock enable with a bus that is not idle.
- R12: Outputs are registered. The decode of the bus sampled at edge k appears after edge k and is replaced at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W (3) | Bank address bits |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| cmd_oh | output | 17 | One-hot decoded command |
| bank_o | output | BANK_W (3) | Bank of a bank-directed command, else zero |
| illegal_o | output | 1 | One-cycle illegal-command pulse |
| pd_o | output | 1 | Power-down status |
| sr_o | output | 1 | Self-refresh status |

## Verification
Directed patterns come first. They walk every strobe code with clock enable held high, then sweep the bank bits across the mode-register writes, which separates the three register selects from the illegal ones. Next they flip address bit 10 on precharge, read and write, which separates each base command from its variant. Clock-enable sequences follow. High-to-low with an idle bus is set against high-to-low with refresh strobes to tell power-down from self-refresh. Low-to-high is run from each mode to tell the two exits apart, and non-idle buses around the clock-enable edges show the illegal cases. A long pseudo-random run with rare clock-enable flips then mixes every transition with every strobe code, against a behavioural model compared on every cycle.

// File: rtl/ddr2dec_pkg.sv
package ddr2dec_pkg;
  localparam int NCMD = 17;

  typedef enum logic [4:0] {
    C_MRS   = 5'd0,
    C_EMRS1 = 5'd1,
    C_EMRS2 = 5'd2,
    C_REF   = 5'd3,
    C_SELF  = 5'd4,
    C_SELFX = 5'd5,
    C_PRE   = 5'd6,
    C_PALL  = 5'd7,
    C_ACT   = 5'd8,
    C_WR    = 5'd9,
    C_WRA   = 5'd10,
    C_RD    = 5'd11,
    C_RDA   = 5'd12,
    C_NOP   = 5'd13,
    C_DESL  = 5'd14,
    C_PDEN  = 5'd15,
    C_PDEX  = 5'd16
  } cmd_e;

  typedef enum logic [1:0] {
    M_ACTIVE  = 2'd0,
    M_PWRDN   = 2'd1,
    M_SELFREF = 2'd2
  } pmode_e;
endpackage

// File: rtl/ddr2dec_cke_track.sv
module ddr2dec_cke_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_prev
);
  // Resets high so the first sampled edge is not mistaken for an exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev <= 1'b1;
    else        cke_prev <= cke;
  end
endmodule

// File: rtl/ddr2dec_classify.sv
module ddr2dec_classify
  import ddr2dec_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic              cke_prev,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  input  pmode_e            mode,
  output logic              hit,
  output cmd_e              cmd,
  output logic              illegal,
  output logic              uses_bank
);
  logic hi_zero;
  logic bus_idle;
  logic [2:0] rcw;

  generate
    if (BANK_W > 2) begin : g_hi
      assign hi_zero = ~|ba[BANK_W-1:2];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign rcw      = {ras_n, cas_n, we_n};
  assign bus_idle = cs_n | (rcw == 3'b111);

  always_comb begin
    hit       = 1'b0;
    cmd       = C_NOP;
    illegal   = 1'b0;
    uses_bank = 1'b0;
    unique case ({cke_prev, cke})
      2'b11: begin
        if (cs_n) begin
          hit = 1'b1; cmd = C_DESL;
        end else begin
          unique case (rcw)
            3'b000: begin
              if (hi_zero && ba[1:0] == 2'b00)      begin hit = 1'b1; cmd = C_MRS;   end
              else if (hi_zero && ba[1:0] == 2'b01) begin hit = 1'b1; cmd = C_EMRS1; end
              else if (hi_zero && ba[1:0] == 2'b10) begin hit = 1'b1; cmd = C_EMRS2; end
              else illegal = 1'b1;
            end
            3'b001: begin hit = 1'b1; cmd = C_REF; end
            3'b010: begin
              hit = 1'b1;
              cmd = a10 ? C_PALL : C_PRE;
              uses_bank = ~a10;
            end
            3'b011: begin hit = 1'b1; cmd = C_ACT; uses_bank = 1'b1; end
            3'b100: begin hit = 1'b1; cmd = a10 ? C_WRA : C_WR; uses_bank = 1'b1; end
            3'b101: begin hit = 1'b1; cmd = a10 ? C_RDA : C_RD; uses_bank = 1'b1; end
            3'b110: illegal = 1'b1;
            default: begin hit = 1'b1; cmd = C_NOP; end
          endcase
        end
      end
      2'b10: begin
        if (bus_idle) begin
          hit = 1'b1; cmd = C_PDEN;
        end else if (rcw == 3'b001) begin
          hit = 1'b1; cmd = C_SELF;
        end else begin
          illegal = 1'b1;
        end
      end
      2'b01: begin
        if (bus_idle) begin
          hit = 1'b1;
          cmd = (mode == M_SELFREF) ? C_SELFX : C_PDEX;
        end else begin
          illegal = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2dec_pwr_state.sv
module ddr2dec_pwr_state
  import ddr2dec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  cmd_e   cmd,
  output pmode_e mode,
  output logic   pd_o,
  output logic   sr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ACTIVE;
    end else if (hit) begin
      case (cmd)
        C_PDEN:         mode <= M_PWRDN;
        C_SELF:         mode <= M_SELFREF;
        C_PDEX, C_SELFX: mode <= M_ACTIVE;
        default: ;
      endcase
    end
  end

  // Status flags trail the mode by one clock (the entry/exit delay).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_o <= 1'b0;
      sr_o <= 1'b0;
    end else begin
      pd_o <= (mode == M_PWRDN);
      sr_o <= (mode == M_SELFREF);
    end
  end

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_o && sr_o));
  p_pd_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == C_PDEN) |-> ##2 pd_o);
  p_pd_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == C_PDEX) |-> ##2 !pd_o);
  p_sr_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == C_SELF) |-> ##2 sr_o);
endmodule

// File: rtl/ddr2_cmd_decoder.sv
module ddr2_cmd_decoder
  import ddr2dec_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  output logic [NCMD-1:0]   cmd_oh,
  output logic [BANK_W-1:0] bank_o,
  output logic              illegal_o,
  output logic              pd_o,
  output logic              sr_o
);
  logic          cke_prev;
  logic          hit;
  logic          illegal;
  logic          uses_bank;
  cmd_e          cmd;
  pmode_e        mode;
  logic [NCMD-1:0] oh_nxt;

  ddr2dec_cke_track u_cke (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cke_prev (cke_prev)
  );

  ddr2dec_classify #(.BANK_W(BANK_W)) u_cls (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke       (cke),
    .cke_prev  (cke_prev),
    .ba        (ba),
    .a10       (a10),
    .mode      (mode),
    .hit       (hit),
    .cmd       (cmd),
    .illegal   (illegal),
    .uses_bank (uses_bank)
  );

  ddr2dec_pwr_state u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .cmd   (cmd),
    .mode  (mode),
    .pd_o  (pd_o),
    .sr_o  (sr_o)
  );

  generate
    for (genvar i = 0; i < NCMD; i++) begin : g_oh
      assign oh_nxt[i] = hit && (cmd == cmd_e'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oh    <= '0;
      bank_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      cmd_oh    <= oh_nxt;
      bank_o    <= (hit && uses_bank) ? ba : '0;
      illegal_o <= illegal;
    end
  end

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_oh));
  p_ill_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cmd_oh == '0));
  p_cke_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cke_prev) |=> (cmd_oh == '0 && !illegal_o));
  p_act_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[C_ACT] |-> (bank_o == $past(ba)));
  p_pall_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[C_PALL] |-> (bank_o == '0));
endmodule

// File: tb/sim_ddr2_cmd_decoder.sv
module sim_ddr2_cmd_decoder;
  localparam int PERIOD = 10;
  localparam int BW = 3;
  localparam int NC = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [BW-1:0] ba = '0;
  logic [NC-1:0] cmd_oh;
  logic [BW-1:0] bank_o;
  logic illegal_o, pd_o, sr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit m_ckep;
  int m_mode;  // 0 active, 1 power-down, 2 self-refresh

  always #(PERIOD/2) clk = ~clk;

  ddr2_cmd_decoder #(.BANK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd_oh(cmd_oh), .bank_o(bank_o), .illegal_o(illegal_o),
    .pd_o(pd_o), .sr_o(sr_o)
  );

  function automatic string tag_of(int c, bit ill, bit ckp, bit ck);
    if (ill) return "R11";
    if (!ckp && !ck) return "R10";
    case (c)
      0, 1, 2: return "R3";
      3, 4:    return "R4";
      5, 16:   return "R9";
      6, 7:    return "R5";
      8:       return "R6";
      9, 10, 11, 12: return "R7";
      13, 14:  return "R2";
      15:      return "R8";
      default: return "R12";
    endcase
  endfunction

  // Apply one bus cycle, then check the registered result against the model.
  task automatic cyc(input bit k, input bit cs, input bit [2:0] rcw,
                     input bit [BW-1:0] b, input bit a);
    int ecmd;
    bit eill, ebk, epd, esr, idle;
    logic [NC-1:0] eoh;
    logic [BW-1:0] eb;
    string t;
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a;
    @(posedge clk);
    #1;
    epd = (m_mode == 1);
    esr = (m_mode == 2);
    ecmd = -1; eill = 0; ebk = 0;
    idle = cs || (rcw == 3'b111);
    if (m_ckep && k) begin
      if (cs) ecmd = 14;
      else if (rcw == 3'b111) ecmd = 13;
      else if (rcw == 3'b000) begin
        if (b == 0) ecmd = 0;
        else if (b == 1) ecmd = 1;
        else if (b == 2) ecmd = 2;
        else eill = 1;
      end
      else if (rcw == 3'b001) ecmd = 3;
      else if (rcw == 3'b010) begin ecmd = a ? 7 : 6; ebk = !a; end
      else if (rcw == 3'b011) begin ecmd = 8; ebk = 1; end
      else if (rcw == 3'b100) begin ecmd = a ? 10 : 9; ebk = 1; end
      else if (rcw == 3'b101) begin ecmd = a ? 12 : 11; ebk = 1; end
      else eill = 1;
    end else if (m_ckep && !k) begin
      if (idle) ecmd = 15;
      else if (rcw == 3'b001) ecmd = 4;
      else eill = 1;
    end else if (!m_ckep && k) begin
      if (idle) ecmd = (m_mode == 2) ? 5 : 16;
      else eill = 1;
    end
    if (ecmd == 15) m_mode = 1;
    if (ecmd == 4) m_mode = 2;
    if (ecmd == 5 || ecmd == 16) m_mode = 0;
    t = tag_of(ecmd, eill, m_ckep, k);
    m_ckep = k;
    eoh = '0;
    if (ecmd >= 0) eoh[ecmd] = 1'b1;
    eb = ebk ? b : '0;
    n_cmp++;
    if (cmd_oh !== eoh || bank_o !== eb || illegal_o !== eill ||
        pd_o !== epd || sr_o !== esr) begin
      n_bad++;
      $display("FAIL %s (R12 timing): got oh=%h bank=%0d ill=%b pd=%b sr=%b exp oh=%h bank=%0d ill=%b pd=%b sr=%b",
               t, cmd_oh, bank_o, illegal_o, pd_o, sr_o, eoh, eb, eill, epd, esr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_ckep = 1; m_mode = 0;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;  // R1 reset state
    if (cmd_oh !== '0 || bank_o !== '0 || illegal_o !== 1'b0 || pd_o !== 1'b0 || sr_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got oh=%h bank=%0d ill=%b pd=%b sr=%b exp all zero",
               cmd_oh, bank_o, illegal_o, pd_o, sr_o);
    end
    @(negedge clk); rst_n = 1'b1;
    #1;
    n_cmp++;  // R1 after release, before a sampling edge
    if (cmd_oh !== '0 || illegal_o !== 1'b0 || pd_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got oh=%h ill=%b pd=%b exp zero", cmd_oh, illegal_o, pd_o);
    end
    // R2
    cyc(1, 1, 3'b000, 3'd5, 1);
    cyc(1, 0, 3'b111, 3'd2, 0);
    // R3 bank select sweep
    for (int b = 0; b < 8; b++) cyc(1, 0, 3'b000, b[BW-1:0], 0);
    // R5, R6, R7
    cyc(1, 0, 3'b010, 3'd5, 0);
    cyc(1, 0, 3'b010, 3'd5, 1);
    cyc(1, 0, 3'b011, 3'd7, 0);
    cyc(1, 0, 3'b100, 3'd3, 0);
    cyc(1, 0, 3'b100, 3'd3, 1);
    cyc(1, 0, 3'b101, 3'd6, 0);
    cyc(1, 0, 3'b101, 3'd6, 1);
    // R11 reserved strobe code
    cyc(1, 0, 3'b110, 3'd1, 0);
    // R4 refresh then self-refresh entry, R10 hold, R9 exit
    cyc(1, 0, 3'b001, 3'd0, 0);
    cyc(0, 0, 3'b001, 3'd0, 0);
    cyc(0, 0, 3'b011, 3'd4, 0);
    cyc(0, 1, 3'b000, 3'd4, 0);
    cyc(1, 1, 3'b111, 3'd0, 0);
    cyc(1, 0, 3'b111, 3'd0, 0);
    cyc(1, 0, 3'b111, 3'd0, 0);
    // R11 bad clock-enable edges
    cyc(0, 0, 3'b011, 3'd2, 0);
    cyc(1, 0, 3'b100, 3'd2, 0);
    // R8 power-down entry, hold, R9 exit
    cyc(1, 0, 3'b111, 3'd0, 0);
    cyc(0, 1, 3'b111, 3'd0, 0);
    cyc(0, 0, 3'b111, 3'd0, 0);
    cyc(0, 0, 3'b111, 3'd0, 0);
    cyc(1, 0, 3'b111, 3'd0, 0);
    cyc(1, 1, 3'b111, 3'd0, 0);
    cyc(1, 1, 3'b111, 3'd0, 0);
    // mixed pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      bit k;
      int r;
      r = $urandom % 8;
      k = (r == 0) ? !cke : cke;
      cyc(k, ($urandom % 5) == 0, 3'($urandom), BW'($urandom), 1'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule